// File: doc/BRIEF.md
# Walsh-Coded Direct-Sequence Chip Spreader

This block produces the baseband transmit chip stream for an underwater acoustic modem. A 3-bit data symbol arrives through a valid/ready handshake. The symbol value selects one of eight length-8 Walsh codes. Every Walsh chip is then spread by a full period of a 7-chip maximal-length sequence, so one composite symbol is 56 antipodal chips long.

The block is paced by a chip-rate enable strobe from outside, nominally 5 kchip/s, which makes a composite symbol 11.2 ms long. After the last chip of a symbol, the block stays silent for another 56 strobes. This guard interval lets multipath echoes die away before the next symbol and halves the net bit rate. A new symbol is taken only once the guard has elapsed.

The chip leaves as a 2-bit signed value together with a chip-valid flag and a guard-active flag. Carrier mixing, pulse shaping and conversion to analog are done downstream.

Top module: `dsss_chip_spreader`

## Requirements
- R1: After reset, sym_ready is 1 and chip_valid, guard_active and chip_out are all 0.
- R2: A symbol is accepted on a clock edge where sym_valid and sym_ready are both 1. From the next cycle, sym_ready stays 0 until the guard interval has ended.
- R3: The Walsh bit for Walsh chip k (0..7, sent in ascending order) of symbol w is the parity of (w AND k).
- R4: Within each Walsh chip, the spreading bits for sub-chips j=0..6 are 0,0,1,0,1,1,1. These come from a 3-bit Fibonacci LFSR with polynomial x^3+x^2+1 that is reloaded with 3'b001 at the start of every Walsh chip.
- R5: The chip bit is the XOR of the Walsh bit and the spreading bit. Bit 0 is sent as chip_out=2'b01 (+1) and bit 1 as 2'b11 (-1). When chip_valid is 0, chip_out is 2'b00.
- R6: While spreading, each cycle with chip_en=1 presents exactly one chip, chip_valid=1, in that same cycle. Composite chip n is sent as Walsh chip n/7 and sub-chip n%7. Cycles without a strobe show no chip and do not advance the sequence.
- R7: After 56 chips, guard_active is 1 and chip_valid is 0 for the next 56 strobes. In the cycle after the 56th guard strobe, sym_ready returns to 1.
- R8: sym_valid and sym_data have no effect while sym_ready is 0. The symbol being sent is unchanged.
- R9: chip_valid is never 1 in a cycle where chip_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip-rate strobe, one cycle per chip period |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 3 | Symbol value, selects the Walsh code |
| sym_ready | output | 1 | Block is idle and will accept a symbol |
| chip_out | output | 2 | Signed chip: 01 = +1, 11 = -1, 00 = none |
| chip_valid | output | 1 | chip_out holds a chip this cycle |
| guard_active | output | 1 | Silent guard interval in progress |

## Verification
A wrong sequence counter or LFSR state shows up directly in chip_out. If the LFSR is not reloaded, the first sub-chip of Walsh chip 1 already differs from the expected value. A Walsh index that advances at the wrong point corrupts a chip within the first 14 strobes for every symbol except 0. A wrong guard count shows as sym_ready rising early or late relative to strobe 112. A symbol latched while busy shows in the very next chip. Because every symbol value is swept under both dense and sparse strobe patterns, each of these faults is seen within a single symbol.

// File: rtl/dsss_spread_pkg.sv
package dsss_spread_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SPREAD = 2'd1,
    PH_GUARD  = 2'd2
  } phase_t;

  // antipodal mapping: 0 -> +1 (2'b01), 1 -> -1 (2'b11)
  function automatic logic [1:0] antipodal(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int          W    = 3,
  parameter logic [W-1:0] SEED = 3'b001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic pn_bit
);

  logic [W-1:0] sr_q, sr_d;
  logic         fb;

  // taps at stages W and W-1 (x^3 + x^2 + 1 for W=3)
  assign fb     = sr_q[W-1] ^ sr_q[W-2];
  assign pn_bit = sr_q[W-1];

  always_comb begin
    sr_d = sr_q;
    if (restart)   sr_d = SEED;
    else if (step) sr_d = {sr_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sr_q <= SEED;
    else if (restart || step) sr_q <= sr_d;
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);

  // R4
  lfsr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sr_q == SEED));

endmodule

// File: rtl/walsh_bit_gen.sv
module walsh_bit_gen #(
  parameter int SYM_W = 3
) (
  input  logic [SYM_W-1:0] row,
  input  logic [SYM_W-1:0] col,
  output logic             wbit
);

  // Hadamard row entry: parity of the bitwise AND of row and column
  assign wbit = ^(row & col);

endmodule

// File: rtl/spread_sequencer.sv
module spread_sequencer
  import dsss_spread_pkg::*;
#(
  parameter int SYM_W     = 3,
  parameter int PN_LEN    = 7,
  parameter int GUARD_LEN = (1 << SYM_W) * PN_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  output logic             sym_ready,
  output logic [SYM_W-1:0] row,
  output logic [SYM_W-1:0] col,
  output logic             chip_fire,
  output logic             pn_restart,
  output logic             pn_step,
  output logic             guard_active
);

  localparam int PN_W = (PN_LEN > 1) ? $clog2(PN_LEN) : 1;
  localparam int GD_W = (GUARD_LEN > 1) ? $clog2(GUARD_LEN) : 1;
  localparam logic [PN_W-1:0]  PN_LAST  = PN_W'(PN_LEN - 1);
  localparam logic [GD_W-1:0]  GD_LAST  = GD_W'(GUARD_LEN - 1);
  localparam logic [SYM_W-1:0] COL_LAST = '1;

  phase_t           ph_q, ph_d;
  logic [SYM_W-1:0] row_q, row_d;
  logic [SYM_W-1:0] col_q, col_d;
  logic [PN_W-1:0]  sub_q, sub_d;
  logic [GD_W-1:0]  gd_q, gd_d;
  logic             accept, sub_last, upd;

  assign sym_ready    = (ph_q == PH_IDLE);
  assign accept       = sym_ready && sym_valid;
  assign chip_fire    = (ph_q == PH_SPREAD) && chip_en;
  assign guard_active = (ph_q == PH_GUARD);
  assign sub_last     = (sub_q == PN_LAST);
  assign pn_restart   = accept || (chip_fire && sub_last);
  assign pn_step      = chip_fire && !sub_last;
  assign row          = row_q;
  assign col          = col_q;
  assign upd          = accept || chip_en;

  always_comb begin
    ph_d  = ph_q;
    row_d = row_q;
    col_d = col_q;
    sub_d = sub_q;
    gd_d  = gd_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (sym_valid) begin
          ph_d  = PH_SPREAD;
          row_d = sym_data;
          col_d = '0;
          sub_d = '0;
        end
      end
      PH_SPREAD: begin
        if (chip_en) begin
          if (sub_last) begin
            sub_d = '0;
            col_d = col_q + 1'b1;
            if (col_q == COL_LAST) begin
              ph_d = PH_GUARD;
              gd_d = '0;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      PH_GUARD: begin
        if (chip_en) begin
          if (gd_q == GD_LAST) ph_d = PH_IDLE;
          else                 gd_d = gd_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      row_q <= '0;
      col_q <= '0;
      sub_q <= '0;
      gd_q  <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      row_q <= row_d;
      col_q <= col_d;
      sub_q <= sub_d;
      gd_q  <= gd_d;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> !sym_ready);

  // R8
  row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_ready && !$past(sym_ready)) |-> $stable(row_q));

  // R7
  guard_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_active |-> !chip_fire);

  // R9
  fire_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_fire |-> chip_en);

  // R6
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !sym_ready) |=> ($stable(sub_q) && $stable(col_q)));

endmodule

// File: rtl/dsss_chip_spreader.sv
module dsss_chip_spreader
  import dsss_spread_pkg::*;
#(
  parameter int SYM_W  = 3,
  parameter int PN_W   = 3,
  parameter int PN_LEN = (1 << PN_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  output logic             sym_ready,
  output logic [1:0]       chip_out,
  output logic             chip_valid,
  output logic             guard_active
);

  localparam int GUARD_LEN = (1 << SYM_W) * PN_LEN;

  logic [SYM_W-1:0] row, col;
  logic             fire, pn_restart, pn_step, pn_bit, wbit;

  spread_sequencer #(
    .SYM_W    (SYM_W),
    .PN_LEN   (PN_LEN),
    .GUARD_LEN(GUARD_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .sym_valid   (sym_valid),
    .sym_data    (sym_data),
    .sym_ready   (sym_ready),
    .row         (row),
    .col         (col),
    .chip_fire   (fire),
    .pn_restart  (pn_restart),
    .pn_step     (pn_step),
    .guard_active(guard_active)
  );

  pn_lfsr #(
    .W   (PN_W),
    .SEED(PN_W'(1))
  ) u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(pn_restart),
    .step   (pn_step),
    .pn_bit (pn_bit)
  );

  walsh_bit_gen #(.SYM_W(SYM_W)) u_walsh (
    .row (row),
    .col (col),
    .wbit(wbit)
  );

  assign chip_valid = fire;
  assign chip_out   = fire ? antipodal(wbit ^ pn_bit) : 2'b00;

  // R5
  chip_antipodal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> (chip_out == 2'b01 || chip_out == 2'b11));

  // R5
  chip_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> (chip_out == 2'b00));

  // R2
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |-> (!chip_valid && !guard_active));

endmodule

// File: tb/test_dsss_chip_spreader.sv
`timescale 1ns/1ps
module test_dsss_chip_spreader;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chip_en;
  logic       sym_valid;
  logic [2:0] sym_data;
  logic       sym_ready;
  logic [1:0] chip_out;
  logic       chip_valid;
  logic       guard_active;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dsss_chip_spreader i_dsss_chip_spreader (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_ready(sym_ready), .chip_out(chip_out),
    .chip_valid(chip_valid), .guard_active(guard_active)
  );

  function automatic logic [1:0] exp_chip(input int w, input int n);
    logic [6:0] pn_seq;
    int k, j;
    logic wb, pb;
    pn_seq = 7'b1110100; // bit j = sub-chip j: 0,0,1,0,1,1,1
    k  = n / 7;
    j  = n % 7;
    wb = ^(3'(w) & 3'(k));
    pb = pn_seq[j];
    return (wb ^ pb) ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; sym_valid = 1'b0; sym_data = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(sym_ready == 1'b1,    "R1 ready",  int'(sym_ready), 1);
    chk(chip_valid == 1'b0,   "R1 valid",  int'(chip_valid), 0);
    chk(guard_active == 1'b0, "R1 guard",  int'(guard_active), 0);
    chk(chip_out == 2'b00,    "R1 chip",   int'(chip_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int pat = 0; pat < 2; pat++) begin
      for (int w = 0; w < 8; w++) begin
        int n, g, cyc;
        bit st;
        @(negedge clk);
        chip_en = 1'b0; sym_valid = 1'b1; sym_data = 3'(w);
        #1;
        chk(sym_ready == 1'b1, "R2 ready idle", int'(sym_ready), 1);
        @(negedge clk);
        // R8: keep offering another symbol while busy on sparse pattern
        if (pat == 1) begin sym_valid = 1'b1; sym_data = 3'(w ^ 5); end
        else          begin sym_valid = 1'b0; end
        n = 0; g = 0; cyc = 0;
        while (n < 56) begin
          st = (pat == 0) ? 1'b1 : ((cyc % 3) == 2);
          chip_en = st;
          #1;
          chk(sym_ready == 1'b0, "R2 busy", int'(sym_ready), 0);
          if (st) begin
            chk(chip_valid == 1'b1, "R6 chip per strobe", int'(chip_valid), 1);
            // R3 R4 R5 R8 chip value
            chk(chip_out == exp_chip(w, n), "R5 chip value R3 R4 R8",
                int'(chip_out), int'(exp_chip(w, n)));
            n++;
          end else begin
            chk(chip_valid == 1'b0, "R9 no strobe no chip", int'(chip_valid), 0);
          end
          cyc++;
          @(negedge clk);
        end
        cyc = 0;
        while (g < 56) begin
          st = (pat == 0) ? 1'b1 : ((cyc % 3) == 2);
          chip_en = st;
          #1;
          chk(guard_active == 1'b1, "R7 guard", int'(guard_active), 1);
          chk(chip_valid == 1'b0,   "R7 silent", int'(chip_valid), 0);
          chk(sym_ready == 1'b0,    "R2 busy guard", int'(sym_ready), 0);
          if (st) g++;
          cyc++;
          @(negedge clk);
        end
        chip_en = 1'b0; sym_valid = 1'b0;
        #1;
        chk(sym_ready == 1'b1,    "R7 ready after guard", int'(sym_ready), 1);
        chk(guard_active == 1'b0, "R7 guard ended", int'(guard_active), 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule